// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The block samples all three lines with its own faster system clock and passes them through two-stage synchronizers. It detects edges on the synchronized select and serial clock, and shifts in one data bit, most significant first, on each falling serial clock edge.

The top four bits of a word choose a target and carry two mode bits. The low twelve bits carry the value. A write to channel A also moves the shared holding buffer into channel B, so both outputs can change on the same edge. The outputs are the two 12-bit latch values, a fast-settling flag and a power-down flag. They feed the converter's analog section.

A transfer is handled by four states. `ST_IDLE` waits for the select to fall (transition *start*). `ST_SHIFT` collects bits. It moves to `ST_FULL` on the 16th falling clock edge (*filled*), or back to `ST_IDLE` when the select rises (*abort/early commit*). `ST_FULL` commits on the next rising serial clock edge and goes to `ST_DONE` (*commit*), or commits and goes to `ST_IDLE` if the select rises first (*release commit*). `ST_DONE` ignores further clocks until the select rises (*release*).

Top module: `dual_dac_frontend`

## Requirements
- R1: A falling select starts a transfer with a cleared shift register. While the select is low, each falling serial clock edge shifts in one data bit, most significant bit first.
- R2: In the assembled 16-bit word, bit 15 is the high select bit, bit 14 the speed bit, bit 13 the power bit and bit 12 the low select bit. Bits 11..0 are the value, with bit 11 as its MSB.
- R3: Select code high=1/low=0 loads the value into channel A and, on the same edge, loads channel B from the holding buffer.
- R4: Select code 0/0 loads the value into both the holding buffer and channel B. Channel A is unchanged.
- R5: Select code 0/1 loads the value into the holding buffer only. Both outputs are unchanged.
- R6: Select code 1/1 sets the power-down output to the power bit. Both latches and the buffer are unchanged.
- R7: Every committed word, whatever its select code, sets the fast flag to the speed bit (1 = fast, 0 = slow).
- R8: After the 16th falling clock edge, the word is committed on the next rising serial clock edge, even while the select stays low. It is not committed before that edge.
- R9: If the select rises after 1 to 15 bits, the partial word is committed as shifted: the received bits occupy the low positions and the upper bits are zero. If the select rises after zero bits, nothing is committed.
- R10: Clock edges after a committed 16-bit word are ignored until the select rises again.
- R11: Reset clears channel A, channel B, the holding buffer, the fast flag and the power-down flag to zero.
- R12: A word sent as two 8-bit bursts, with the select held low and the clock idle between them, gives the same result as one 16-clock burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sdin | input | 1 | Serial data in, MSB first |
| chan_a | output | 12 | Channel A latch value |
| chan_b | output | 12 | Channel B latch value |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow |
| pwr_down | output | 1 | 1 = converter powered down |

## Verification
The bench holds the serial clock low after the 16th falling edge and checks that nothing changes until the clock rises. A design that committed on the falling edge would fail that check. It then clocks extra bits before releasing the select; a design that kept counting would clobber a channel with the trailing bits. A zero-bit select pulse and an 8-bit partial word test the early-commit rule: a faulty design would either write garbage on the empty pulse or drop the partial word. Split 8-bit bursts and the channel A write that also moves the buffer into channel B expose designs that reset state between bursts or load channel B from the wrong source.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int DATA_W = 12;
    localparam int CTRL_W = 4;
    localparam int WORD_W = DATA_W + CTRL_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;

    // {high select bit, low select bit}
    typedef enum logic [1:0] {
        SEL_BUF_B = 2'b00,
        SEL_BUF   = 2'b01,
        SEL_A     = 2'b10,
        SEL_CTRL  = 2'b11
    } target_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int               LINES   = 3,
    parameter int               STAGES  = 2,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);
    logic [STAGES:0][LINES-1:0] pipe;
    assign pipe[0] = d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g+1] <= RST_VAL;
            else        pipe[g+1] <= pipe[g];
        end
    end

    assign q = pipe[STAGES];
endmodule

// File: rtl/dacfe_xfer.sv
module dacfe_xfer
    import dacfe_pkg::*;
#(
    parameter int W     = WORD_W,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sdin,
    output logic         commit,
    output logic [W-1:0] word
);
    xfer_state_t state, state_nx;
    logic             cs_q, sclk_q;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;

    wire cs_fall = cs_q & ~cs_n;
    wire cs_rise = ~cs_q & cs_n;
    wire ck_fall = sclk_q & ~sclk;
    wire ck_rise = ~sclk_q & sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT: if (cs_rise) state_nx = ST_IDLE;
                      else if (ck_fall && cnt == CNT_W'(W - 1)) state_nx = ST_FULL;
            ST_FULL:  if (cs_rise) state_nx = ST_IDLE;
                      else if (ck_rise) state_nx = ST_DONE;
            ST_DONE:  if (cs_rise) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            cnt    <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            unique case (state)
                ST_IDLE: if (cs_fall) begin
                    shreg <= '0;
                    cnt   <= '0;
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        commit <= (cnt != '0);
                    end else if (ck_fall) begin
                        shreg <= {shreg[W-2:0], sdin};
                        cnt   <= cnt + 1'b1;
                    end
                end
                ST_FULL: commit <= cs_rise | ck_rise;
                ST_DONE: ;
            endcase
        end
    end

    assign word = shreg;

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(W));
    // R8
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R10
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> $stable(shreg));
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    output logic [DATA_W-1:0] chan_a,
    output logic [DATA_W-1:0] chan_b,
    output logic              fast_mode,
    output logic              pwr_down
);
    localparam int SEL_HI_BIT = WORD_W - 1;
    localparam int SPD_BIT    = WORD_W - 2;
    localparam int PWR_BIT    = WORD_W - 3;
    localparam int SEL_LO_BIT = WORD_W - 4;

    logic [DATA_W-1:0] hold_buf;
    target_t           tgt;
    logic [DATA_W-1:0] value;

    assign tgt   = target_t'({word[SEL_HI_BIT], word[SEL_LO_BIT]});
    assign value = word[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_a    <= '0;
            chan_b    <= '0;
            hold_buf  <= '0;
            fast_mode <= 1'b0;
            pwr_down  <= 1'b0;
        end else if (wr_en) begin
            fast_mode <= word[SPD_BIT];
            unique case (tgt)
                SEL_A: begin
                    chan_a <= value;
                    chan_b <= hold_buf;
                end
                SEL_BUF_B: begin
                    hold_buf <= value;
                    chan_b   <= value;
                end
                SEL_BUF:  hold_buf <= value;
                SEL_CTRL: pwr_down <= word[PWR_BIT];
            endcase
        end
    end

    // R3
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && tgt == SEL_A) |=> $stable(chan_a));
    // R6
    pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && tgt == SEL_CTRL) |=> $stable(pwr_down));
    // R3
    b_from_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == SEL_A) |=> chan_b == $past(hold_buf));
    // R7
    fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fast_mode));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [DATA_W-1:0] chan_a,
    output logic [DATA_W-1:0] chan_b,
    output logic              fast_mode,
    output logic              pwr_down
);
    logic [2:0]        lines_s;
    logic              commit;
    logic [WORD_W-1:0] word;

    dacfe_sync #(.LINES(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, sclk, sdin}), .q(lines_s)
    );

    dacfe_xfer #(.W(WORD_W)) i_xfer (
        .clk(clk), .rst_n(rst_n),
        .cs_n(lines_s[2]), .sclk(lines_s[1]), .sdin(lines_s[0]),
        .commit(commit), .word(word)
    );

    dacfe_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(commit), .word(word),
        .chan_a(chan_a), .chan_b(chan_b),
        .fast_mode(fast_mode), .pwr_down(pwr_down)
    );
endmodule

// File: tb/test_dual_dac_frontend.sv
module test_dual_dac_frontend;
    localparam int HALF = 4;
    localparam int NV   = 8;
    // {word, exp A, exp B, exp fast, exp pwr}
    localparam logic [41:0] VEC [NV] = '{
        {16'h1123, 12'h000, 12'h000, 1'b0, 1'b0},  // R5 buffer only
        {16'hC456, 12'h456, 12'h123, 1'b1, 1'b0},  // R3 A + B from buffer
        {16'h4789, 12'h456, 12'h789, 1'b1, 1'b0},  // R4 buffer and B
        {16'hB000, 12'h456, 12'h789, 1'b0, 1'b1},  // R6 power on
        {16'h9ABC, 12'h456, 12'h789, 1'b0, 1'b0},  // R6 power off
        {16'hFFFF, 12'h456, 12'h789, 1'b1, 1'b1},  // R7 fast via ctrl
        {16'h8FFF, 12'hFFF, 12'h789, 1'b0, 1'b1},  // R2 full value
        {16'h0000, 12'hFFF, 12'h000, 1'b0, 1'b1}   // R4 zero
    };

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
    logic [11:0] chan_a, chan_b;
    logic fast_mode, pwr_down;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    dual_dac_frontend i_dual_dac_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
        .chan_a(chan_a), .chan_b(chan_b), .fast_mode(fast_mode), .pwr_down(pwr_down)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] ea, input logic [11:0] eb,
                         input logic ef, input logic ep);
        total++;
        if (chan_a !== ea || chan_b !== eb || fast_mode !== ef || pwr_down !== ep) begin
            bad++;
            $display("FAIL %s: got a=%h b=%h f=%b p=%b expected a=%h b=%h f=%b p=%b",
                     req, chan_a, chan_b, fast_mode, pwr_down, ea, eb, ef, ep);
        end
    endtask

    task automatic send_bit(input logic b);
        sdin = b;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(HALF);
        sclk = 1'b1;
    endtask

    task automatic shift_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic sel_low();
        wait_clk(1);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic sel_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    initial begin
        wait_clk(3);
        check("R11 reset", 12'h000, 12'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 R2 table walk
        for (int k = 0; k < NV; k++) begin
            sel_low();
            shift_bits(VEC[k][41:26], 16);
            sel_high();
            check($sformatf("R1 vector %0d", k), VEC[k][25:14], VEC[k][13:2],
                  VEC[k][1], VEC[k][0]);
        end

        // R12 two 8-bit bursts
        sel_low();
        shift_bits(16'h00C3, 8);
        wait_clk(40);
        shift_bits(16'h0021, 8);
        sel_high();
        check("R12 split bursts", 12'h321, 12'h000, 1'b1, 1'b1);

        // R9 zero-bit select pulse commits nothing
        sel_low();
        sel_high();
        check("R9 empty pulse", 12'h321, 12'h000, 1'b1, 1'b1);

        // R8 commit only on rising clock after 16th fall
        sel_low();
        shift_bits(16'h4ABC >> 1, 15);
        sdin = 1'b0;
        wait_clk(HALF);
        sclk = 1'b0;
        wait_clk(20);
        check("R8 before rising edge", 12'h321, 12'h000, 1'b1, 1'b1);
        sclk = 1'b1;
        wait_clk(12);
        check("R8 after rising edge", 12'h321, 12'hABC, 1'b1, 1'b1);
        // R10 trailing bits ignored
        shift_bits(16'h00FF, 8);
        sel_high();
        check("R10 extra bits", 12'h321, 12'hABC, 1'b1, 1'b1);

        // R9 partial word: 8 bits land low, code 00
        sel_low();
        shift_bits(16'h005A, 8);
        sel_high();
        check("R9 partial word", 12'h321, 12'h05A, 1'b0, 1'b1);

        // R3 channel A write pulls buffer into B
        sel_low();
        shift_bits(16'h8111, 16);
        sel_high();
        check("R3 A write", 12'h111, 12'h05A, 1'b0, 1'b1);

        // R11 reset mid-run
        rst_n = 1'b0;
        wait_clk(2);
        check("R11 reset again", 12'h000, 12'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
        wait_clk(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule